// File: doc/BRIEF.md
# Prescaled General Purpose Timer Channel

This block is one programmable timer channel. Software sets it up through three 32-bit registers on a simple register bus. A load register holds a clock divider and a period. A mode register holds the run, repeat, interrupt-enable and function-select controls. A status register holds a sticky terminal-count flag. While the channel runs in its timer function, a prescale stage divides the input clock, and a period stage counts the divided ticks. When the period stage reaches its terminal value, the flag is set and an interrupt may be raised.

The channel either fires once and then disables itself, or it reloads and repeats with no gap between periods. The load register can be rewritten while the timer runs. The new values are taken up at the next terminal-count reload, so a period already in progress is never cut short. The register bus is a plain single-cycle interface with no back-pressure. A write completes on the clock edge where `bus_sel` and `bus_we` are both high. Read data is a combinational function of `bus_addr` alone.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, all three registers read zero and `irq` is low.
- R2: Address map: 0 is the mode register, 1 is the load register, 2 is status, and 3 reads zero. The load register is stored and read back whole. Its bits 31:16 give the divider and its bits 15:0 give the period.
- R3: The status flag is set on exactly the clock edge that falls D×N edges after the write that enabled the timer. D is the divider value, with 0 meaning 65536. N is the period value, with 0 meaning 65536.
- R4: When mode bit 10 is clear, the timer fires once. On that terminal edge, mode bit 12 (run) clears itself, and no further terminal count occurs.
- R5: When mode bit 10 is set, the timer fires every D×N edges without a lost cycle, and the run bit stays set.
- R6: Counting happens only while mode bits 2:0 equal 4 (timer function) and bit 12 is set. With any other function code, both stages hold their values.
- R7: Writing the mode register with bit 12 clear stops the timer, and the other mode fields are kept as written. A write that sets bit 12 when it was clear restarts both stages from zero.
- R8: Status bit 0 is sticky. Writing 1 to it clears it, and writing 0 has no effect. A terminal count on the same edge as a clearing write leaves the flag set.
- R9: `irq` is high exactly when the status flag is set and mode bit 8 (interrupt enable) is set.
- R10: A load-register write made while the timer runs does not affect the current period. It takes effect from the next terminal-count reload.
- R11: The mode register keeps only bits 17:16, 12, 10, 9, 8, 5:4 and 2:0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the prescaler input |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the exact edge on which the flag sets. It checks the edge before and the edge itself for divider values 1, 2 and the zero-encoded 65536, and for a zero-encoded period. A design off by one in either stage, or one that decodes zero as divide-by-zero, would fire one edge early or late, or never fire. Repeat mode is checked across consecutive periods, so a reload that costs a cycle would drift one edge late. A load write in the middle of a period, and a clear that coincides with a terminal count, expose a design that applies new values at once or lets the clear win. Stop/restart and a non-timer function code are checked for held counters and for a restart from zero.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    ADR_MODE = 2'd0,
    ADR_LOAD = 2'd1,
    ADR_STAT = 2'd2,
    ADR_NONE = 2'd3
  } ptmr_addr_e;

  localparam int BIT_RUN    = 12;
  localparam int BIT_REPEAT = 10;
  localparam int BIT_IRQEN  = 8;
  localparam int BIT_FLAG   = 0;
  localparam int DIV_LSB    = 16;

  localparam logic [2:0]  FN_TIMER  = 3'd4;
  localparam logic [31:0] MODE_KEEP = 32'h0003_1737;
endpackage

// File: rtl/ptmr_stage.sv
module ptmr_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  input  logic [W:0]   limit,
  output logic [W-1:0] value,
  output logic         wrap
);
  localparam logic [W:0] ONE = (W+1)'(1);

  logic [W-1:0] val_q;
  logic         at_end;

  assign at_end = ({1'b0, val_q} == (limit - ONE));
  assign wrap   = step & at_end;
  assign value  = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       val_q <= '0;
    else if (restart) val_q <= '0;
    else if (step) begin
      if (at_end) val_q <= '0;
      else        val_q <= val_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tc,
  output logic              run_en,
  output logic              repeat_en,
  output logic              irq_en,
  output logic [2:0]        fn_sel,
  output logic [DIV_W-1:0]  cfg_div,
  output logic [PER_W-1:0]  cfg_per,
  output logic              start,
  output logic              flag,
  output logic              irq
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(MODE_KEEP);

  logic [DATA_W-1:0] mode_q, load_q;
  logic              flag_q;
  logic              wr, wr_mode, wr_load, wr_stat;

  assign wr      = bus_sel & bus_we;
  assign wr_mode = wr & (bus_addr == ADR_MODE);
  assign wr_load = wr & (bus_addr == ADR_LOAD);
  assign wr_stat = wr & (bus_addr == ADR_STAT);

  assign start = wr_mode & bus_wdata[BIT_RUN] & ~mode_q[BIT_RUN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      load_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_mode)
        mode_q <= bus_wdata & KEEP;
      else if (tc && !mode_q[BIT_REPEAT])
        mode_q[BIT_RUN] <= 1'b0;
      if (wr_load)
        load_q <= bus_wdata;
      if (tc)
        flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[BIT_FLAG])
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_MODE: bus_rdata = mode_q;
      ADR_LOAD: bus_rdata = load_q;
      ADR_STAT: bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign run_en    = mode_q[BIT_RUN];
  assign repeat_en = mode_q[BIT_REPEAT];
  assign irq_en    = mode_q[BIT_IRQEN];
  assign fn_sel    = mode_q[2:0];
  assign cfg_div   = load_q[DIV_LSB +: DIV_W];
  assign cfg_per   = load_q[PER_W-1:0];
  assign flag      = flag_q;
  assign irq       = flag_q & mode_q[BIT_IRQEN];
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [DIV_W:0] DIV_FULL = {1'b1, {DIV_W{1'b0}}};
  localparam logic [PER_W:0] PER_FULL = {1'b1, {PER_W{1'b0}}};

  logic              run_en, repeat_en, irq_en, start, flag, running, tc, pre_wrap;
  logic [2:0]        fn_sel;
  logic [DIV_W-1:0]  cfg_div, act_div, pre_cnt;
  logic [PER_W-1:0]  cfg_per, act_per, per_cnt;
  logic [DIV_W:0]    pre_lim;
  logic [PER_W:0]    per_lim;

  ptmr_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tc(tc), .run_en(run_en), .repeat_en(repeat_en), .irq_en(irq_en),
    .fn_sel(fn_sel), .cfg_div(cfg_div), .cfg_per(cfg_per),
    .start(start), .flag(flag), .irq(irq)
  );

  assign running = run_en & (fn_sel == FN_TIMER);

  // active copies, taken up on start and on each terminal-count reload
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_div <= '0;
      act_per <= '0;
    end else if (start || tc) begin
      act_div <= cfg_div;
      act_per <= cfg_per;
    end
  end

  assign pre_lim = (act_div == '0) ? DIV_FULL : {1'b0, act_div};
  assign per_lim = (act_per == '0) ? PER_FULL : {1'b0, act_per};

  ptmr_stage #(.W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start), .step(running),
    .limit(pre_lim), .value(pre_cnt), .wrap(pre_wrap)
  );

  ptmr_stage #(.W(PER_W)) u_per (
    .clk(clk), .rst_n(rst_n), .restart(start), .step(pre_wrap),
    .limit(per_lim), .value(per_cnt), .wrap(tc)
  );
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int PER_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              run_en,
  input logic              repeat_en,
  input logic              running,
  input logic              start,
  input logic              tc,
  input logic              flag,
  input logic [DIV_W-1:0]  pre_cnt,
  input logic [PER_W-1:0]  per_cnt,
  input logic [DIV_W:0]    pre_lim,
  input logic [PER_W:0]    per_lim
);
  logic mode_wr, clr_wr;
  assign mode_wr = bus_sel && bus_we && (bus_addr == 2'd0);
  assign clr_wr  = bus_sel && bus_we && (bus_addr == 2'd2) && bus_wdata[0];

  a_r3_tc_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> flag);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_wr |=> flag);
  a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    tc && !repeat_en && !mode_wr |=> !run_en);
  a_r5_repeat_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    tc && repeat_en && !mode_wr |=> run_en);
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !start |=> $stable(pre_cnt) && $stable(per_cnt));
  a_r3_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pre_cnt} < pre_lim);
  a_r3_per_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, per_cnt} < per_lim);
endmodule

bind prescaled_timer ptmr_checker #(.DATA_W(DATA_W), .DIV_W(DIV_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .run_en(run_en),
  .repeat_en(repeat_en), .running(running), .start(start), .tc(tc),
  .flag(flag), .pre_cnt(pre_cnt), .per_cnt(per_cnt),
  .pre_lim(pre_lim), .per_lim(per_lim)
);

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RUN = 32'h1000, RPT = 32'h0400, IEN = 32'h0100, FN = 32'h0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  prescaled_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    cyc++;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_to(input int k);
    while (cyc < k) begin @(negedge clk); cyc++; end
  endtask

  task automatic flag_is(input string req, input logic exp);
    logic [31:0] d;
    rd(2'd2, d);
    chk(req, d, {31'b0, exp});
  endtask

  task automatic tidy();
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 mode", d, 0);
    rd(2'd1, d); chk("R1 load", d, 0);
    rd(2'd2, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(2'd1, 32'h0002_0003);
    rd(2'd1, d); chk("R2 load readback", d, 32'h0002_0003);
    wr(2'd0, RUN | IEN | FN); cyc = 0;
    wait_to(5);  flag_is("R3 div2 x3 early", 0);
    wait_to(6);  flag_is("R3 div2 x3 edge", 1);
    chk("R9 irq with enable", {31'b0, irq}, 1);
    rd(2'd0, d); chk("R4 run self-clears", d, IEN | FN);
    wr(2'd2, 32'h0);
    flag_is("R8 write zero ignored", 1);
    wr(2'd2, 32'h1);
    flag_is("R8 write one clears", 0);
    chk("R9 irq drops", {31'b0, irq}, 0);
    wait_to(cyc + 20); flag_is("R4 no second fire", 0);
    tidy();
  endtask

  task automatic t_repeat();
    logic [31:0] d;
    wr(2'd1, 32'h0001_0004);
    wr(2'd0, RUN | RPT | FN); cyc = 0;
    wait_to(3); flag_is("R5 first early", 0);
    wait_to(4); flag_is("R5 first edge", 1);
    wr(2'd2, 32'h1); flag_is("R8 cleared", 0);
    wait_to(7); flag_is("R5 second early", 0);
    wr(2'd2, 32'h1);
    flag_is("R8 set wins over clear", 1);
    rd(2'd0, d); chk("R5 run stays set", d, RUN | RPT | FN);
    tidy();
  endtask

  task automatic t_reload();
    logic [31:0] d;
    wr(2'd1, 32'h0001_0004);
    wr(2'd0, RUN | RPT | FN); cyc = 0;
    wait_to(1);
    wr(2'd1, 32'h0001_0008);
    rd(2'd1, d); chk("R2 new load readback", d, 32'h0001_0008);
    wait_to(3); flag_is("R10 old period early", 0);
    wait_to(4); flag_is("R10 old period kept", 1);
    wr(2'd2, 32'h1);
    wait_to(11); flag_is("R10 new period early", 0);
    wait_to(12); flag_is("R10 new period edge", 1);
    tidy();
  endtask

  task automatic t_stop_restart();
    logic [31:0] d;
    wr(2'd1, 32'h0001_000A);
    wr(2'd0, RUN | RPT | IEN | FN); cyc = 0;
    wait_to(5);
    wr(2'd0, RPT | IEN | FN);
    rd(2'd0, d); chk("R7 fields kept on stop", d, RPT | IEN | FN);
    wait_to(cyc + 20); flag_is("R7 stopped", 0);
    wr(2'd0, RUN | RPT | IEN | FN); cyc = 0;
    wait_to(9);  flag_is("R7 restart early", 0);
    wait_to(10); flag_is("R7 restart from zero", 1);
    tidy();
  endtask

  task automatic t_fnsel();
    wr(2'd1, 32'h0001_0003);
    wr(2'd0, RUN | 32'h1);
    wait_to(cyc + 20); flag_is("R6 capture code holds", 0);
    wr(2'd0, RUN | FN); cyc = 0;
    wait_to(2); flag_is("R6 timer code early", 0);
    wait_to(3); flag_is("R6 timer code edge", 1);
    chk("R9 irq gated off", {31'b0, irq}, 0);
    wr(2'd0, IEN);
    chk("R9 irq after enable", {31'b0, irq}, 1);
    tidy();
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_EFF0);
    rd(2'd0, d); chk("R11 kept bits", d, 32'h0003_0730);
    rd(2'd3, d); chk("R2 spare address", d, 0);
    tidy();
  endtask

  task automatic t_wide();
    wr(2'd1, 32'h0000_0001);
    wr(2'd0, RUN | FN); cyc = 0;
    wait_to(65535); flag_is("R3 div zero early", 0);
    wait_to(65536); flag_is("R3 div zero edge", 1);
    tidy();
    wr(2'd1, 32'h0001_0000);
    wr(2'd0, RUN | FN); cyc = 0;
    wait_to(65535); flag_is("R3 period zero early", 0);
    wait_to(65536); flag_is("R3 period zero edge", 1);
    tidy();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_repeat();
    t_reload();
    t_stop_restart();
    t_fnsel();
    t_fields();
    t_wide();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule